// File: doc/BRIEF.md
# Dual-Width Reorder Buffer with Head Flush

This block keeps the program order of a two-wide out-of-order core. In one cycle it takes up to two newly renamed instructions from dispatch and places them at the tail of a circular queue. It also takes completion reports from two writeback ports and a memory-ordering violation mark from the load/store unit. In the same cycle it retires up to two finished instructions from the head, handing their physical tags to the free list and the architected map.

Each entry records the instruction class, its destination physical tag, the tag it replaced, a done bit, a mispredict flag and a violation flag. A memory instruction also records the tail index of the other memory queue, sampled when it was dispatched: a load records the store-queue tail and a store records the load-queue tail. A flagged instruction never leaves quietly. When it reaches the head and is done, the buffer raises a flush with a cause bit. That instruction retires in slot 0 with the flush, anything behind it is dropped, and the queue is empty on the next cycle so that the rename state can be restored from the architected copy.

Top module: `reorder_buf`

## Requirements
- R1: After reset the buffer is empty: no retire slot is valid, flush is low, full is low, and the first allocation index is 0.
- R2: An accepted slot 0 instruction is written at the tail index shown on `allocIdx0`. An accepted slot 1 instruction goes at `allocIdx1`, which is the next index modulo the depth. The tail advances by the number accepted and wraps from the last index to 0.
- R3: `full` is high whenever fewer than two entries are free. While it is high no dispatch request is accepted.
- R4: An entry of class load (code 1) retires with the store-queue tail it saw at dispatch. An entry of class store (code 2) retires with the load-queue tail it saw at dispatch. Entries of class ALU (code 0) and branch (code 3) retire with a snapshot of 0.
- R5: Retirement is strictly in order. Slot 0 retires the head entry exactly when the buffer is not empty and the head is done, and it presents that entry's destination tag, previous tag and class.
- R6: Slot 1 retires the entry after the head only in a cycle when slot 0 retires without a flush, that entry is done, and it carries no mispredict or violation flag.
- R7: A completion report on either port sets the done bit of the named entry from the next cycle. The port's mispredict bit is recorded in the same entry.
- R8: A violation mark flags the named entry. Entries older than it keep retiring normally. When the flagged entry flushes, `flushViol` is 1; for a mispredict-only flush it is 0.
- R9: When the head is done and flagged, `flush` is high and slot 1 does not retire. On the next cycle the buffer is empty with its tail unchanged. Dispatch requests made in the flush cycle are not accepted.
- R10: A slot 1 request without a slot 0 request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dispValid | input | 2 | Dispatch requests, bit 0 = older slot |
| dispKind0 | input | 2 | Class of slot 0 (0 ALU, 1 load, 2 store, 3 branch) |
| dispKind1 | input | 2 | Class of slot 1 |
| dispDest0 | input | TAG_W | Destination physical tag, slot 0 |
| dispDest1 | input | TAG_W | Destination physical tag, slot 1 |
| dispPrev0 | input | TAG_W | Replaced physical tag, slot 0 |
| dispPrev1 | input | TAG_W | Replaced physical tag, slot 1 |
| ldqTail | input | QIDX_W | Current load-queue tail |
| stqTail | input | QIDX_W | Current store-queue tail |
| cmplValid | input | 2 | Completion report per writeback port |
| cmplIdx | input | 2 x IDX_W | Buffer index per completion port |
| cmplMisp | input | 2 | Mispredict bit per completion port |
| violValid | input | 1 | Violation mark strobe |
| violIdx | input | IDX_W | Buffer index of the violating load |
| allocIdx0 | output | IDX_W | Index a slot 0 instruction receives |
| allocIdx1 | output | IDX_W | Index a slot 1 instruction receives |
| full | output | 1 | Fewer than two free entries |
| retValid | output | 2 | Retire strobes, bit 0 = head |
| retKind0 | output | 2 | Class retiring in slot 0 |
| retKind1 | output | 2 | Class retiring in slot 1 |
| retDest0 | output | TAG_W | Destination tag retiring in slot 0 |
| retDest1 | output | TAG_W | Destination tag retiring in slot 1 |
| retPrev0 | output | TAG_W | Replaced tag freed by slot 0 |
| retPrev1 | output | TAG_W | Replaced tag freed by slot 1 |
| retSnap0 | output | QIDX_W | Opposite-queue tail of slot 0 |
| retSnap1 | output | QIDX_W | Opposite-queue tail of slot 1 |
| flush | output | 1 | Flagged head retiring, empty the pipeline |
| flushViol | output | 1 | Flush cause: 1 violation, 0 mispredict |

## Verification
The bench builds the block with its defaults: depth 16, 6-bit tags and 3-bit queue indices. At that depth a few thousand cycles of mixed traffic wrap the head and tail pointers many times. They also fill the queue to its last two entries over and over, and they push flushes through every head position, with the head alone, the head plus its neighbour, and a full queue. The mix covers every dispatch request pattern, every instruction class, out-of-order completion on both ports, and violation marks on loads a few places behind the head.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int TAG_W  = 6;
  localparam int QIDX_W = 3;

  typedef enum logic [1:0] {
    KIND_ALU    = 2'd0,
    KIND_LOAD   = 2'd1,
    KIND_STORE  = 2'd2,
    KIND_BRANCH = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [TAG_W-1:0]  dest;
    logic [TAG_W-1:0]  prev;
    logic [QIDX_W-1:0] snap;
    logic              done;
    logic              misp;
    logic              viol;
  } entry_t;

  typedef struct packed {
    logic alloc0;
    logic alloc1;
    logic retire0;
    logic retire1;
    logic flush;
  } strobe_t;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl #(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               dispValid,
  input  logic                     headDone0,
  input  logic                     headFlag0,
  input  logic                     headDone1,
  input  logic                     headFlag1,
  output rob_pkg::strobe_t         ctl,
  output logic [$clog2(DEPTH)-1:0] allocIdx0,
  output logic [$clog2(DEPTH)-1:0] allocIdx1,
  output logic [$clog2(DEPTH)-1:0] headIdx0,
  output logic [$clog2(DEPTH)-1:0] headIdx1,
  output logic                     full
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] headPtr, tailPtr, count;
  logic nonEmpty, twoPlus;

  assign count    = tailPtr - headPtr;
  assign nonEmpty = (count != '0);
  assign twoPlus  = (count >= PTR_W'(2));
  assign full     = (count > PTR_W'(DEPTH - 2));

  assign headIdx0  = headPtr[IDX_W-1:0];
  assign headIdx1  = headIdx0 + IDX_W'(1);
  assign allocIdx0 = tailPtr[IDX_W-1:0];
  assign allocIdx1 = allocIdx0 + IDX_W'(1);

  always_comb begin
    ctl.retire0 = nonEmpty && headDone0;
    ctl.flush   = ctl.retire0 && headFlag0;
    ctl.retire1 = ctl.retire0 && !ctl.flush && twoPlus && headDone1 && !headFlag1;
    ctl.alloc0  = dispValid[0] && !full && !ctl.flush;
    ctl.alloc1  = ctl.alloc0 && dispValid[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else if (ctl.flush) begin
      headPtr <= tailPtr;
    end else begin
      headPtr <= headPtr + PTR_W'(ctl.retire0) + PTR_W'(ctl.retire1);
      tailPtr <= tailPtr + PTR_W'(ctl.alloc0) + PTR_W'(ctl.alloc1);
    end
  end

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    count <= PTR_W'(DEPTH));
  p_full_holds_tail_r3: assert property (@(posedge clk) disable iff (!rstN)
    full |=> (tailPtr == $past(tailPtr)));
  p_slot1_after_slot0_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.retire1 |-> ctl.retire0);
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> (count == '0));
  p_flush_squash_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |-> !ctl.retire1);
endmodule

// File: rtl/rob_data.sv
module rob_data #(
  parameter int DEPTH = 16
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  rob_pkg::strobe_t                    ctl,
  input  logic [$clog2(DEPTH)-1:0]            allocIdx0,
  input  logic [$clog2(DEPTH)-1:0]            allocIdx1,
  input  logic [$clog2(DEPTH)-1:0]            headIdx0,
  input  logic [$clog2(DEPTH)-1:0]            headIdx1,
  input  logic [1:0]                          dispKind0,
  input  logic [1:0]                          dispKind1,
  input  logic [rob_pkg::TAG_W-1:0]           dispDest0,
  input  logic [rob_pkg::TAG_W-1:0]           dispDest1,
  input  logic [rob_pkg::TAG_W-1:0]           dispPrev0,
  input  logic [rob_pkg::TAG_W-1:0]           dispPrev1,
  input  logic [rob_pkg::QIDX_W-1:0]          ldqTail,
  input  logic [rob_pkg::QIDX_W-1:0]          stqTail,
  input  logic [1:0]                          cmplValid,
  input  logic [1:0][$clog2(DEPTH)-1:0]       cmplIdx,
  input  logic [1:0]                          cmplMisp,
  input  logic                                violValid,
  input  logic [$clog2(DEPTH)-1:0]            violIdx,
  output rob_pkg::entry_t                     head0,
  output rob_pkg::entry_t                     head1
);
  import rob_pkg::*;
  localparam int IDX_W = $clog2(DEPTH);

  entry_t newEnt0, newEnt1;
  entry_t entArr [DEPTH];

  function automatic entry_t buildEntry(input logic [1:0] kindIn,
                                        input logic [TAG_W-1:0] destIn,
                                        input logic [TAG_W-1:0] prevIn);
    entry_t e;
    e      = '0;
    e.kind = kind_e'(kindIn);
    e.dest = destIn;
    e.prev = prevIn;
    if (kind_e'(kindIn) == KIND_LOAD)       e.snap = stqTail;
    else if (kind_e'(kindIn) == KIND_STORE) e.snap = ldqTail;
    return e;
  endfunction

  assign newEnt0 = buildEntry(dispKind0, dispDest0, dispPrev0);
  assign newEnt1 = buildEntry(dispKind1, dispDest1, dispPrev1);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    entry_t entR;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entR <= '0;
      end else if (ctl.alloc0 && allocIdx0 == MY_IDX) begin
        entR <= newEnt0;
      end else if (ctl.alloc1 && allocIdx1 == MY_IDX) begin
        entR <= newEnt1;
      end else begin
        for (int p = 0; p < 2; p++) begin
          if (cmplValid[p] && cmplIdx[p] == MY_IDX) begin
            entR.done <= 1'b1;
            entR.misp <= cmplMisp[p];
          end
        end
        if (violValid && violIdx == MY_IDX) entR.viol <= 1'b1;
      end
    end

    assign entArr[i] = entR;
  end

  assign head0 = entArr[headIdx0];
  assign head1 = entArr[headIdx1];

  p_cmpl_sets_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmplValid[0] && !(ctl.alloc0 && allocIdx0 == cmplIdx[0])
                  && !(ctl.alloc1 && allocIdx1 == cmplIdx[0]))
      |=> entArr[$past(cmplIdx[0])].done);
  p_viol_sticks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (violValid && !(ctl.alloc0 && allocIdx0 == violIdx)
               && !(ctl.alloc1 && allocIdx1 == violIdx))
      |=> entArr[$past(violIdx)].viol);
  p_alloc_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.alloc0 |=> !entArr[$past(allocIdx0)].done);
endmodule

// File: rtl/reorder_buf.sv
module reorder_buf #(
  parameter int DEPTH  = 16,
  parameter int TAG_W  = rob_pkg::TAG_W,
  parameter int QIDX_W = rob_pkg::QIDX_W,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            dispValid,
  input  logic [1:0]            dispKind0,
  input  logic [1:0]            dispKind1,
  input  logic [TAG_W-1:0]      dispDest0,
  input  logic [TAG_W-1:0]      dispDest1,
  input  logic [TAG_W-1:0]      dispPrev0,
  input  logic [TAG_W-1:0]      dispPrev1,
  input  logic [QIDX_W-1:0]     ldqTail,
  input  logic [QIDX_W-1:0]     stqTail,
  input  logic [1:0]            cmplValid,
  input  logic [1:0][IDX_W-1:0] cmplIdx,
  input  logic [1:0]            cmplMisp,
  input  logic                  violValid,
  input  logic [IDX_W-1:0]      violIdx,
  output logic [IDX_W-1:0]      allocIdx0,
  output logic [IDX_W-1:0]      allocIdx1,
  output logic                  full,
  output logic [1:0]            retValid,
  output logic [1:0]            retKind0,
  output logic [1:0]            retKind1,
  output logic [TAG_W-1:0]      retDest0,
  output logic [TAG_W-1:0]      retDest1,
  output logic [TAG_W-1:0]      retPrev0,
  output logic [TAG_W-1:0]      retPrev1,
  output logic [QIDX_W-1:0]     retSnap0,
  output logic [QIDX_W-1:0]     retSnap1,
  output logic                  flush,
  output logic                  flushViol
);
  rob_pkg::strobe_t ctl;
  rob_pkg::entry_t  head0, head1;
  logic [IDX_W-1:0] headIdx0, headIdx1;

  initial begin
    if (TAG_W != rob_pkg::TAG_W || QIDX_W != rob_pkg::QIDX_W)
      $error("reorder_buf: field widths must match rob_pkg");
    if ((1 << IDX_W) != DEPTH)
      $error("reorder_buf: DEPTH must be a power of two");
  end

  rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid),
    .headDone0(head0.done), .headFlag0(head0.misp | head0.viol),
    .headDone1(head1.done), .headFlag1(head1.misp | head1.viol),
    .ctl(ctl), .allocIdx0(allocIdx0), .allocIdx1(allocIdx1),
    .headIdx0(headIdx0), .headIdx1(headIdx1), .full(full)
  );

  rob_data #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .allocIdx0(allocIdx0), .allocIdx1(allocIdx1),
    .headIdx0(headIdx0), .headIdx1(headIdx1),
    .dispKind0(dispKind0), .dispKind1(dispKind1),
    .dispDest0(dispDest0), .dispDest1(dispDest1),
    .dispPrev0(dispPrev0), .dispPrev1(dispPrev1),
    .ldqTail(ldqTail), .stqTail(stqTail),
    .cmplValid(cmplValid), .cmplIdx(cmplIdx), .cmplMisp(cmplMisp),
    .violValid(violValid), .violIdx(violIdx),
    .head0(head0), .head1(head1)
  );

  assign retValid  = {ctl.retire1, ctl.retire0};
  assign retKind0  = head0.kind;
  assign retKind1  = head1.kind;
  assign retDest0  = head0.dest;
  assign retDest1  = head1.dest;
  assign retPrev0  = head0.prev;
  assign retPrev1  = head1.prev;
  assign retSnap0  = head0.snap;
  assign retSnap1  = head1.snap;
  assign flush     = ctl.flush;
  assign flushViol = ctl.flush && head0.viol;

  p_flush_at_head_r9: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> retValid[0]);
  p_viol_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    flushViol |-> flush);
endmodule

// File: tb/sim_reorder_buf.sv
module sim_reorder_buf;
  localparam int DEPTH = 16;
  localparam int TW = 6;
  localparam int QW = 3;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [1:0] dispValid = '0, dispKind0 = '0, dispKind1 = '0;
  logic [TW-1:0] dispDest0 = '0, dispDest1 = '0, dispPrev0 = '0, dispPrev1 = '0;
  logic [QW-1:0] ldqTail = '0, stqTail = '0;
  logic [1:0] cmplValid = '0, cmplMisp = '0;
  logic [1:0][IW-1:0] cmplIdx = '0;
  logic violValid = 1'b0;
  logic [IW-1:0] violIdx = '0;
  logic [IW-1:0] allocIdx0, allocIdx1;
  logic full, flush, flushViol;
  logic [1:0] retValid, retKind0, retKind1;
  logic [TW-1:0] retDest0, retDest1, retPrev0, retPrev1;
  logic [QW-1:0] retSnap0, retSnap1;

  reorder_buf u0 (.*);

  int checks = 0, errors = 0;
  int mHead = 0, mCount = 0;
  int mKind [DEPTH], mDest [DEPTH], mPrev [DEPTH], mSnap [DEPTH];
  bit mDone [DEPTH], mMisp [DEPTH], mViol [DEPTH];
  logic [31:0] lfsr = 32'h1234_5678;
  int flushSeen = 0, violSeen = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rnd(input int m);
    for (int k = 0; k < 7; k++) lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return int'(lfsr[15:0]) % m;
  endfunction

  function automatic int snapOf(input int kind, input int lq, input int sq);
    return kind == 1 ? sq : (kind == 2 ? lq : 0);
  endfunction

  // Compare outputs against the model, then advance the model over one edge.
  task automatic cycle();
    int h0, h1, tail, n;
    bit e0, e1, eF;
    h0 = mHead; h1 = (mHead + 1) % DEPTH; tail = (mHead + mCount) % DEPTH;
    e0 = mCount > 0 && mDone[h0];
    eF = e0 && (mMisp[h0] || mViol[h0]);
    e1 = e0 && !eF && mCount >= 2 && mDone[h1] && !mMisp[h1] && !mViol[h1];
    chk("R3 full", int'(full), int'(mCount >= DEPTH - 1));
    chk("R2 allocIdx0", int'(allocIdx0), tail);
    chk("R2 allocIdx1", int'(allocIdx1), (tail + 1) % DEPTH);
    chk("R5 R7 retValid0", int'(retValid[0]), int'(e0));
    chk("R6 retValid1", int'(retValid[1]), int'(e1));
    chk("R9 flush", int'(flush), int'(eF));
    if (eF) begin
      flushSeen++;
      if (mViol[h0]) violSeen++;
      chk("R8 flushViol", int'(flushViol), int'(mViol[h0]));
    end
    if (e0) begin
      chk("R5 retDest0", int'(retDest0), mDest[h0]);
      chk("R5 retPrev0", int'(retPrev0), mPrev[h0]);
      chk("R5 retKind0", int'(retKind0), mKind[h0]);
      chk("R4 retSnap0", int'(retSnap0), mSnap[h0]);
    end
    if (e1) begin
      chk("R6 retDest1", int'(retDest1), mDest[h1]);
      chk("R6 retPrev1", int'(retPrev1), mPrev[h1]);
      chk("R4 retSnap1", int'(retSnap1), mSnap[h1]);
    end
    for (int p = 0; p < 2; p++)
      if (cmplValid[p]) begin mDone[cmplIdx[p]] = 1; mMisp[cmplIdx[p]] = cmplMisp[p]; end
    if (violValid) mViol[violIdx] = 1;
    if (eF) begin
      mHead = tail; mCount = 0;
    end else begin
      n = int'(e0) + int'(e1);
      mHead = (mHead + n) % DEPTH; mCount -= n;
      if (dispValid[0] && mCount + n < DEPTH - 1) begin
        mKind[tail] = dispKind0; mDest[tail] = dispDest0; mPrev[tail] = dispPrev0;
        mSnap[tail] = snapOf(dispKind0, ldqTail, stqTail);
        mDone[tail] = 0; mMisp[tail] = 0; mViol[tail] = 0; mCount++;
        if (dispValid[1]) begin
          tail = (tail + 1) % DEPTH;
          mKind[tail] = dispKind1; mDest[tail] = dispDest1; mPrev[tail] = dispPrev1;
          mSnap[tail] = snapOf(dispKind1, ldqTail, stqTail);
          mDone[tail] = 0; mMisp[tail] = 0; mViol[tail] = 0; mCount++;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    dispValid = '0; cmplValid = '0; cmplMisp = '0; violValid = 0;
  endtask

  task automatic randomStim(input int dispPct, input int cmplPct);
    int o;
    dispValid = rnd(100) < dispPct ? 2'(rnd(4)) : 2'b00;
    dispKind0 = 2'(rnd(4)); dispKind1 = 2'(rnd(4));
    dispDest0 = TW'(rnd(64)); dispDest1 = TW'(rnd(64));
    dispPrev0 = TW'(rnd(64)); dispPrev1 = TW'(rnd(64));
    ldqTail = QW'(rnd(8)); stqTail = QW'(rnd(8));
    for (int p = 0; p < 2; p++)
      if (mCount > 0 && rnd(100) < cmplPct) begin
        o = (mHead + rnd(mCount)) % DEPTH;
        if (!mDone[o] && !(p == 1 && cmplValid[0] && cmplIdx[0] == IW'(o))) begin
          cmplValid[p] = 1; cmplIdx[p] = IW'(o);
          cmplMisp[p] = (mKind[o] == 3) && rnd(5) == 0;
        end
      end
    if (mCount > 3 && rnd(6) == 0) begin
      o = (mHead + 2 + rnd(mCount - 2)) % DEPTH;
      if (mKind[o] == 1 && mDone[o]) begin violValid = 1; violIdx = IW'(o); end
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mKind[i] = 0; mDest[i] = 0; mPrev[i] = 0; mSnap[i] = 0;
      mDone[i] = 0; mMisp[i] = 0; mViol[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1 retValid", int'(retValid), 0);
    chk("R1 flush", int'(flush), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 full", int'(full), 0);
    chk("R1 allocIdx0", int'(allocIdx0), 0);
    // R10: slot 1 alone must not allocate.
    dispValid = 2'b10; dispKind1 = 2'd1;
    cycle();
    chk("R10 slot1 alone ignored", int'(allocIdx0), 0);
    // R3: fill to capacity with paired dispatch, then keep pushing.
    for (int c = 0; c < 11; c++) begin
      dispValid = 2'b11; dispKind0 = 2'(c % 4); dispKind1 = 2'((c + 1) % 4);
      dispDest0 = TW'(2 * c); dispDest1 = TW'(2 * c + 1);
      dispPrev0 = TW'(40 + c); dispPrev1 = TW'(20 + c);
      ldqTail = QW'(c); stqTail = QW'(7 - (c % 8));
      cycle();
    end
    chk("R3 full at capacity", int'(full), 1);
    // Complete youngest first; retirement must stay in order.
    for (int k = DEPTH - 1; k >= 0; k--) begin
      cmplValid = 2'b01; cmplIdx[0] = IW'(k);
      cycle();
    end
    repeat (10) cycle();
    chk("R5 drained", int'(retValid), 0);
    // R9: mispredicted branch at head with a done neighbour behind it.
    dispValid = 2'b11; dispKind0 = 2'd3; dispKind1 = 2'd0;
    cycle();
    cmplValid = 2'b11; cmplIdx[0] = IW'(mHead); cmplMisp[0] = 1;
    cmplIdx[1] = IW'((mHead + 1) % DEPTH);
    cycle();
    chk("R9 directed flush", int'(flush), 1);
    dispValid = 2'b11;
    cycle();
    chk("R9 empty after flush", int'(retValid), 0);
    // Mixed sweep over traffic densities.
    for (int phase = 0; phase < 6; phase++)
      for (int c = 0; c < 600; c++) begin
        randomStim(30 + 12 * phase, 20 + 10 * phase);
        cycle();
      end
    chk("R9 flushes exercised", int'(flushSeen > 5), 1);
    chk("R8 violation flushes exercised", int'(violSeen > 0), 1);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule